// File: doc/BRIEF.md
# Sampling Phase Auto-Search Controller

This block picks the clock phase at which the front-end stream is digitized. It selects each candidate phase in turn on an external phase generator, waits for the new phase to settle, and then watches the 12-bit sample stream for a fixed window. While the trigger is held off, the stream carries only idle synchronization pulses. For each phase the block records the smallest and largest sample seen in the window, and the difference between them is that phase's peak-to-peak amplitude.

When every phase has been tried, the block applies the phase with the largest amplitude and derives a discrimination threshold for the downstream header parser from that phase's stored extremes. It then raises trigger enable. A start pulse throws away all results and runs the search again from phase 0. The search also runs on its own after reset.

Top module: `phase_search_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, phaseSel is 0, trigEnable is 0 and threshold is 0. The search then begins at phase 0 with no start pulse.
- R2: trigEnable stays low from reset or start until the search completes.
- R3: During a search phaseSel moves through 0, 1, … 23, and each step adds exactly one.
- R4: Each phase is held for max(settleLen,1) settle cycles, then a 1024-cycle measurement window, then one evaluation cycle. That is settleLen+1025 cycles in total when settleLen ≥ 1.
- R5: Samples that arrive during the settle cycles do not affect any measured range.
- R6: A phase's range is its window maximum minus its window minimum. The phase with the largest range is applied on phaseSel at completion.
- R7: When ranges are equal, the lower-numbered phase wins.
- R8: At completion, threshold equals the best phase's minimum plus floor(range/2).
- R9: phaseSel, threshold and trigEnable all take their final values on the same clock edge, one cycle after the evaluation of phase 23. They then hold until the next start.
- R10: A start pulse in any state sets phaseSel to 0, trigEnable to 0 and threshold to 0 on the next edge, clears the stored best result and starts the search again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that restarts the search |
| settleLen | input | 8 | Settle cycles after each phase change |
| sampleIn | input | 12 | Digitized front-end sample |
| phaseSel | output | 5 | Phase number driven to the clock-phase generator |
| trigEnable | output | 1 | High once the search is complete |
| threshold | output | 12 | Header discrimination threshold for the parser |

## Verification
The assertions assume three things about the inputs. First, start is a single-cycle pulse. Second, settleLen changes only on the cycle of a start pulse or while the block is idle in completion. Third, the phase generator obeys phaseSel, so the stream's amplitude follows it. The stimulus drives start and settleLen only at those moments. It builds each sample from the phase currently selected: a fixed baseline with a pulse whose height depends on the phase. During the settle cycles it deliberately injects full-scale spikes, which are legal data that the block must ignore.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE  = 3'd0,
    ST_MEASURE = 3'd1,
    ST_EVAL    = 3'd2,
    ST_SETBEST = 3'd3,
    ST_DONE    = 3'd4
  } searchState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBest;
    logic track;
    logic firstSample;
    logic evaluate;
    logic applyBest;
  } dpStrobe_t;

endpackage

// File: rtl/psc_control.sv
module psc_control
  import psc_pkg::*;
#(
  parameter int NUM_PHASES = 24,
  parameter int WINDOW     = 1024,
  parameter int SETTLE_W   = 8,
  localparam int PH_W      = $clog2(NUM_PHASES),
  localparam int WIN_W     = $clog2(WINDOW),
  localparam int CNT_W     = ((WIN_W > SETTLE_W) ? WIN_W : SETTLE_W) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settleLen,
  input  logic [PH_W-1:0]     bestPhase,
  output logic [PH_W-1:0]     phase,
  output logic                searchDone,
  output dpStrobe_t           strb
);

  searchState_t st;
  logic [CNT_W-1:0] cnt;
  logic settleEnd;
  logic windowEnd;
  logic lastPhase;

  assign settleEnd = (cnt + 1'b1) >= CNT_W'(settleLen);
  assign windowEnd = (cnt == CNT_W'(WINDOW - 1));
  assign lastPhase = (phase == PH_W'(NUM_PHASES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= ST_SETTLE;
      cnt   <= '0;
      phase <= '0;
    end else if (start) begin
      st    <= ST_SETTLE;
      cnt   <= '0;
      phase <= '0;
    end else begin
      case (st)
        ST_SETTLE: begin
          if (settleEnd) begin
            st  <= ST_MEASURE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_MEASURE: begin
          if (windowEnd) begin
            st  <= ST_EVAL;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_EVAL: begin
          if (lastPhase) begin
            st <= ST_SETBEST;
          end else begin
            phase <= phase + 1'b1;
            st    <= ST_SETTLE;
          end
        end
        ST_SETBEST: begin
          phase <= bestPhase;
          st    <= ST_DONE;
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    strb.clrBest     = start;
    strb.track       = (st == ST_MEASURE) && !start;
    strb.firstSample = (cnt == '0);
    strb.evaluate    = (st == ST_EVAL) && !start;
    strb.applyBest   = (st == ST_SETBEST) && !start;
  end

  assign searchDone = (st == ST_DONE);

endmodule

// File: rtl/psc_datapath.sv
module psc_datapath
  import psc_pkg::*;
#(
  parameter int NUM_PHASES = 24,
  parameter int SAMPLE_W   = 12,
  localparam int PH_W      = $clog2(NUM_PHASES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [PH_W-1:0]     curPhase,
  output logic [PH_W-1:0]     bestPhase,
  output logic [SAMPLE_W-1:0] threshold
);

  logic [SAMPLE_W-1:0] curMin, curMax;
  logic [SAMPLE_W-1:0] bestMin, bestMax;
  logic [SAMPLE_W-1:0] curRange, bestRange;
  logic                bestValid;
  logic                takeNew;

  assign curRange  = curMax - curMin;
  assign bestRange = bestMax - bestMin;
  // strict compare keeps the earlier (lower) phase on a tie
  assign takeNew   = !bestValid || (curRange > bestRange);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMin <= '0;
      curMax <= '0;
    end else if (strb.track) begin
      if (strb.firstSample) begin
        curMin <= sampleIn;
        curMax <= sampleIn;
      end else begin
        if (sampleIn < curMin) curMin <= sampleIn;
        if (sampleIn > curMax) curMax <= sampleIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestValid <= 1'b0;
      bestMin   <= '0;
      bestMax   <= '0;
      bestPhase <= '0;
      threshold <= '0;
    end else if (strb.clrBest) begin
      bestValid <= 1'b0;
      bestMin   <= '0;
      bestMax   <= '0;
      bestPhase <= '0;
      threshold <= '0;
    end else if (strb.evaluate) begin
      if (takeNew) begin
        bestValid <= 1'b1;
        bestMin   <= curMin;
        bestMax   <= curMax;
        bestPhase <= curPhase;
      end
    end else if (strb.applyBest) begin
      threshold <= bestMin + (bestRange >> 1);
    end
  end

endmodule

// File: rtl/phase_search_ctrl.sv
module phase_search_ctrl
  import psc_pkg::*;
#(
  parameter int NUM_PHASES = 24,
  parameter int SAMPLE_W   = 12,
  parameter int WINDOW     = 1024,
  parameter int SETTLE_W   = 8,
  localparam int PH_W      = $clog2(NUM_PHASES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settleLen,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [PH_W-1:0]     phaseSel,
  output logic                trigEnable,
  output logic [SAMPLE_W-1:0] threshold
);

  dpStrobe_t       strb;
  logic [PH_W-1:0] bestPhase;

  psc_control #(
    .NUM_PHASES(NUM_PHASES),
    .WINDOW    (WINDOW),
    .SETTLE_W  (SETTLE_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .settleLen (settleLen),
    .bestPhase (bestPhase),
    .phase     (phaseSel),
    .searchDone(trigEnable),
    .strb      (strb)
  );

  psc_datapath #(
    .NUM_PHASES(NUM_PHASES),
    .SAMPLE_W  (SAMPLE_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .sampleIn (sampleIn),
    .curPhase (phaseSel),
    .bestPhase(bestPhase),
    .threshold(threshold)
  );

endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int NUM_PHASES = 24,
  parameter int SAMPLE_W   = 12,
  localparam int PH_W      = $clog2(NUM_PHASES)
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic [PH_W-1:0]     phaseSel,
  input logic                trigEnable,
  input logic [SAMPLE_W-1:0] threshold
);

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!trigEnable && phaseSel == '0 && threshold == '0)); // R10

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    phaseSel < PH_W'(NUM_PHASES)); // R3

  AST_PHASE_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!trigEnable && !$past(start) && phaseSel != $past(phaseSel))
      |-> (phaseSel == $past(phaseSel) + 1'b1)); // R3

  AST_THR_ZERO_IN_SEARCH: assert property (@(posedge clk) disable iff (!rstN)
    !trigEnable |-> (threshold == '0)); // R2

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (trigEnable && !start) |=> trigEnable); // R9

  AST_DONE_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (trigEnable && $past(trigEnable)) |-> ($stable(threshold) && $stable(phaseSel))); // R9

endmodule

bind phase_search_ctrl psc_checker #(
  .NUM_PHASES(NUM_PHASES),
  .SAMPLE_W  (SAMPLE_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .phaseSel  (phaseSel),
  .trigEnable(trigEnable),
  .threshold (threshold)
);

// File: tb/sim_phase_search_ctrl.sv
`timescale 1ns/1ps
module sim_phase_search_ctrl;

  localparam int NPH = 24;
  localparam int WIN = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  settleLen = 8'd16;
  logic [11:0] sampleIn = 12'd800;
  logic [4:0]  phaseSel;
  logic        trigEnable;
  logic [11:0] threshold;

  int checks = 0;
  int fails  = 0;
  int mode   = 0;
  int tick   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  phase_search_ctrl u0 (
    .clk(clk), .rstN(rstN), .start(start), .settleLen(settleLen),
    .sampleIn(sampleIn), .phaseSel(phaseSel), .trigEnable(trigEnable),
    .threshold(threshold)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 settle,1 measure,2 eval,3 setbest,4 done
  int mSt, mCnt, mPh, mMin, mMax, mBV, mBR, mBP, mBMin, mBMax, mThr;
  always @(posedge clk or negedge rstN) begin
    if (!rstN || start) begin
      mSt = 0; mCnt = 0; mPh = 0; mThr = 0; mBV = 0; mBR = 0;
      mBP = 0; mBMin = 0; mBMax = 0; mMin = 0; mMax = 0;
    end else begin
      case (mSt)
        0: if (mCnt + 1 >= int'(settleLen)) begin mSt = 1; mCnt = 0; end
           else mCnt++;
        1: begin
          if (mCnt == 0) begin mMin = sampleIn; mMax = sampleIn; end
          else begin
            if (sampleIn < mMin) mMin = sampleIn;
            if (sampleIn > mMax) mMax = sampleIn;
          end
          if (mCnt == WIN - 1) begin mSt = 2; mCnt = 0; end else mCnt++;
        end
        2: begin
          if (mBV == 0 || (mMax - mMin) > mBR) begin
            mBV = 1; mBR = mMax - mMin; mBP = mPh; mBMin = mMin; mBMax = mMax;
          end
          if (mPh == NPH - 1) mSt = 3; else begin mPh++; mSt = 0; end
        end
        3: begin mPh = mBP; mThr = mBMin + mBR / 2; mSt = 4; end
        default: ;
      endcase
    end
  end

  function automatic int amp(input int md, input int ph);
    int d;
    case (md)
      0: begin d = (ph > 13) ? ph - 13 : 13 - ph; return 1500 - 60 * d; end
      1: return (ph == 5 || ph == 17) ? 1001 : 300;
      default: return (ph == 3) ? 3000 : 200;
    endcase
  endfunction

  // per-phase dwell and step bookkeeping
  int prevPh = 0, runLen = 0, dur1 = 0, upSteps = 0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R4 phaseSel vs model", phaseSel, mPh);
      check("R2 trigEnable vs model", trigEnable, (mSt == 4) ? 1 : 0);
      check("R8 threshold vs model", threshold, mThr);
      if (phaseSel == prevPh) runLen++;
      else begin
        if (prevPh == 1 && phaseSel == 2) dur1 = runLen;
        if (!trigEnable && phaseSel == prevPh + 1) upSteps++;
        runLen = 1;
      end
      prevPh = phaseSel;
    end
    tick++;
    if (mSt == 0) sampleIn = tick[0] ? 12'd4095 : 12'd0;  // R5 settle spikes
    else sampleIn = 12'(800 + (((tick % 32) < 4) ? amp(mode, mPh) : 0));
  end

  task automatic waitDone();
    for (int i = 0; i < 60000 && !trigEnable; i++) @(negedge clk);
    #1;
  endtask

  task automatic pulseStart(input int newSettle);
    @(negedge clk); #1;
    start = 1'b1; settleLen = 8'(newSettle);
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset phaseSel", phaseSel, 0);
    check("R1 reset trigEnable", trigEnable, 0);
    check("R1 reset threshold", threshold, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R1 first cycle phaseSel", phaseSel, 0);
    check("R2 low during search", trigEnable, 0);

    waitDone();
    check("R9 done reached", trigEnable, 1);
    check("R6 best phase largest range", phaseSel, 13);
    check("R8 R5 threshold mid of best", threshold, 1550);
    check("R4 phase dwell settle16", dur1, 16 + WIN + 1);
    check("R3 ascending steps", upSteps, NPH - 1);
    repeat (50) @(negedge clk);
    #1;
    check("R9 trigEnable held", trigEnable, 1);
    check("R9 phase held", phaseSel, 13);

    mode = 2;
    upSteps = 0;
    pulseStart(5);
    check("R10 restart phase", phaseSel, 0);
    check("R10 restart trig", trigEnable, 0);
    check("R10 restart threshold", threshold, 0);
    for (int i = 0; i < 60000 && phaseSel != 10; i++) @(negedge clk);
    check("R4 phase dwell settle5", dur1, 5 + WIN + 1);
    mode = 1;
    pulseStart(5);
    check("R10 mid-search restart phase", phaseSel, 0);
    check("R10 mid-search restart trig", trigEnable, 0);
    upSteps = 0;
    waitDone();
    check("R7 tie keeps lower phase", phaseSel, 5);
    check("R10 old best discarded", (phaseSel == 3) ? 1 : 0, 0);
    check("R8 threshold odd range floor", threshold, 1300);
    check("R3 ascending steps rerun", upSteps, NPH - 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule